// File: doc/BRIEF.md
# Contactless Frame CRC Engine

This block computes and checks the checksum that guards contactless frames, one byte per clock. On the transmit side, bytes enter with start-of-frame and end-of-frame markers. Each byte comes out one cycle later, unchanged. When appending is enabled, the checksum bytes follow straight after the last data byte. On the receive side, the engine runs over a whole frame, checksum included. One cycle after the end-of-frame byte it raises a single-cycle pass or fail strobe.

Two checksum widths are supported:
- **16-bit:** polynomial x^16+x^12+x^5+1, processed least significant bit first.
- **5-bit:** polynomial x^5+x^3+1, processed most significant bit first.

The start value of the CRC register comes either from a small table of fixed presets or from a programmable 16-bit value. The first byte of a frame can be left out of the calculation.

Configuration is captured on the start-of-frame byte and held for the rest of the frame. While the transmit path is appending, the byte source must leave the input idle: for two cycles in 16-bit mode, or one cycle in 5-bit mode. Bytes offered during those cycles are dropped.

Top module: `crc_frame_engine`

## Requirements
- R1: After reset, tx_out_valid, tx_out_data, tx_out_last, rx_crc_ok and rx_crc_err are all 0.
- R2: Every byte accepted with tx_valid appears unchanged on tx_out_data, with tx_out_valid high, exactly one cycle later.
- R3: In 16-bit mode the CRC uses x^16+x^12+x^5+1, with bit 0 of each byte first and the register shifting right. The result is appended low byte then high byte, in the two cycles after the end-of-frame byte is output. tx_out_last is set on the high byte only.
- R4: In 5-bit mode the CRC uses x^5+x^3+1, with bit 7 of each byte first. It is appended as one byte carrying the CRC in bits 4:0, with bits 7:5 zero. tx_out_last is set on that byte.
- R5: cfg_preset_sel picks the start value: 000=0000h, 001=6363h, 010=A671h, 011=FFFFh, 100=0012h, 101=E012h, 110=0000h, 111=cfg_preset_val. In 5-bit mode only bits 4:0 of the start value are used.
- R6: With tx_crc_inv set, the appended checksum is the bitwise complement of the CRC (in 5-bit mode, of bits 4:0). With it clear, the CRC is sent unmodified.
- R7: With cfg_skip_first set, the first byte of a frame is left out of the CRC on both paths. It is still passed through on transmit.
- R8: With tx_crc_en clear, nothing is appended, and tx_out_last is set on the end-of-frame byte.
- R9: All configuration inputs are taken on the start-of-frame byte. Changes during the rest of the frame have no effect on that frame's checksum.
- R10: In 16-bit mode with rx_crc_en set, the CRC is run over all received bytes. The frame passes if the residue is 0000h (rx_crc_inv=0) or F0B8h (rx_crc_inv=1). The result appears one cycle after the end-of-frame byte as a one-cycle pulse on rx_crc_ok or on rx_crc_err, never both.
- R11: In 5-bit mode with rx_crc_en set, bits 4:0 of the last byte are compared with the CRC of the bytes before it, or with its complement when rx_crc_inv=1. The strobe timing is the same as in R10.
- R12: With rx_crc_en clear, no receive strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_preset_sel | input | 3 | Start value select code |
| cfg_preset_val | input | 16 | Programmable start value (code 111) |
| cfg_crc5 | input | 1 | 1 = 5-bit CRC, 0 = 16-bit CRC |
| cfg_skip_first | input | 1 | Leave the first frame byte out of the CRC |
| tx_crc_en | input | 1 | Append a checksum on transmit |
| tx_crc_inv | input | 1 | Append the complemented checksum |
| rx_crc_en | input | 1 | Check the checksum on receive |
| rx_crc_inv | input | 1 | Expect the inverted residue on receive |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_sof | input | 1 | First byte of transmit frame |
| tx_eof | input | 1 | Last byte of transmit frame |
| tx_out_valid | output | 1 | Outgoing byte valid |
| tx_out_data | output | 8 | Outgoing byte (data or checksum) |
| tx_out_last | output | 1 | Final byte of the outgoing frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of receive frame |
| rx_eof | input | 1 | Last byte of receive frame |
| rx_crc_ok | output | 1 | One-cycle pass strobe |
| rx_crc_err | output | 1 | One-cycle fail strobe |

## Verification
Transmit bytes come out one cycle after they are accepted. The first checksum byte follows the end-of-frame byte in the next cycle, and the high byte follows in the cycle after that. The receive verdict is due one cycle after the end-of-frame byte is clocked in. The bench drives inputs on falling edges and records outputs on falling edges into a capture buffer and strobe counters. Each frame is then given several idle cycles before its contents, its tx_out_last position and its strobe counts are compared with a model computed from the requirements.

// File: rtl/crc_cfg_pkg.sv
package crc_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam int CRC5_W = 5;
    localparam int SEL_W  = 3;

    localparam logic [CRC_W-1:0]  POLY16_REFL = 16'h8408;
    localparam logic [CRC5_W-1:0] POLY5       = 5'h09;
    localparam logic [CRC_W-1:0]  RESIDUE_INV = 16'hF0B8;
    localparam logic [CRC_W-1:0]  RESIDUE_STD = 16'h0000;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CRC_W-1:0] pval;
        logic             crc5;
        logic             skip;
        logic             inv;
        logic             en;
    } crc_cfg_t;

    function automatic logic [CRC_W-1:0] crc_preset(input crc_cfg_t c);
        logic [CRC_W-1:0] p;
        case (c.sel)
            3'd0:    p = 16'h0000;
            3'd1:    p = 16'h6363;
            3'd2:    p = 16'hA671;
            3'd3:    p = 16'hFFFF;
            3'd4:    p = 16'h0012;
            3'd5:    p = 16'hE012;
            3'd7:    p = c.pval;
            default: p = 16'h0000;
        endcase
        if (c.crc5) begin
            p = {{(CRC_W-CRC5_W){1'b0}}, p[CRC5_W-1:0]};
        end
        return p;
    endfunction

    function automatic logic [CRC_W-1:0] step16(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ POLY16_REFL;
        end
        return r;
    endfunction

    function automatic logic [CRC5_W-1:0] step5(input logic [CRC5_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
        logic [CRC5_W-1:0] r;
        logic fb;
        r = c;
        for (int i = BYTE_W-1; i >= 0; i--) begin
            fb = r[CRC5_W-1] ^ d[i];
            r  = {r[CRC5_W-2:0], 1'b0};
            if (fb) r = r ^ POLY5;
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c,
                                                       input logic is5,
                                                       input logic [BYTE_W-1:0] d);
        if (is5) return {{(CRC_W-CRC5_W){1'b0}}, step5(c[CRC5_W-1:0], d)};
        return step16(c, d);
    endfunction

endpackage

// File: rtl/crc_frame_cfg.sv
module crc_frame_cfg
    import crc_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     take,
    input  crc_cfg_t cfg_live,
    output crc_cfg_t cfg_eff
);

    crc_cfg_t held_d, held_q;

    always_comb begin
        held_d  = held_q;
        if (take) held_d = cfg_live;
        cfg_eff = take ? cfg_live : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

endmodule

// File: rtl/crc_tx_path.sv
module crc_tx_path
    import crc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  crc_cfg_t          cfg_live,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_sof,
    input  logic              tx_eof,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              tx_out_last
);

    typedef enum logic [1:0] {TX_IDLE, TX_APP_LO, TX_APP_HI} tx_phase_e;

    typedef struct packed {
        tx_phase_e         ph;
        logic [CRC_W-1:0]  crc;
        logic [CRC_W-1:0]  fcs;
        logic              fcs5;
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              ol;
    } tx_state_t;

    tx_state_t st_d, st_q;
    crc_cfg_t  eff;
    logic      accept;
    logic [CRC_W-1:0] base, upd;

    assign accept = tx_valid && (st_q.ph == TX_IDLE);

    crc_frame_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (accept && tx_sof),
        .cfg_live (cfg_live),
        .cfg_eff  (eff)
    );

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        st_d.ol = 1'b0;
        base    = tx_sof ? crc_preset(eff) : st_q.crc;
        upd     = (tx_sof && eff.skip) ? base : crc_step_byte(base, eff.crc5, tx_data);
        case (st_q.ph)
            TX_IDLE: begin
                if (accept) begin
                    st_d.ov  = 1'b1;
                    st_d.od  = tx_data;
                    st_d.crc = upd;
                    if (tx_eof) begin
                        if (eff.en) begin
                            st_d.ph   = TX_APP_LO;
                            st_d.fcs  = eff.inv ? ~upd : upd;
                            st_d.fcs5 = eff.crc5;
                        end else begin
                            st_d.ol = 1'b1;
                        end
                    end
                end
            end
            TX_APP_LO: begin
                st_d.ov = 1'b1;
                if (st_q.fcs5) begin
                    st_d.od = {{(BYTE_W-CRC5_W){1'b0}}, st_q.fcs[CRC5_W-1:0]};
                    st_d.ol = 1'b1;
                    st_d.ph = TX_IDLE;
                end else begin
                    st_d.od = st_q.fcs[BYTE_W-1:0];
                    st_d.ph = TX_APP_HI;
                end
            end
            TX_APP_HI: begin
                st_d.ov = 1'b1;
                st_d.od = st_q.fcs[CRC_W-1:BYTE_W];
                st_d.ol = 1'b1;
                st_d.ph = TX_IDLE;
            end
            default: st_d.ph = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_out_valid = st_q.ov;
    assign tx_out_data  = st_q.od;
    assign tx_out_last  = st_q.ol;

    // R2: accepted byte reappears unchanged one cycle later
    p_pass_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tx_out_valid && tx_out_data == $past(tx_data)));

    // R8: with appending off, the end byte closes the frame
    p_no_append_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tx_eof && !eff.en) |=> tx_out_last);

    // R3: the last marker only ever rides on a valid byte
    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_last |-> tx_out_valid);

endmodule

// File: rtl/crc_rx_path.sv
module crc_rx_path
    import crc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  crc_cfg_t          cfg_live,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              rx_crc_ok,
    output logic              rx_crc_err
);

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             ok;
        logic             err;
    } rx_state_t;

    rx_state_t st_d, st_q;
    crc_cfg_t  eff;
    logic [CRC_W-1:0]  base, upd;
    logic [CRC5_W-1:0] exp5;
    logic              match;

    crc_frame_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (rx_valid && rx_sof),
        .cfg_live (cfg_live),
        .cfg_eff  (eff)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ok  = 1'b0;
        st_d.err = 1'b0;
        base     = rx_sof ? crc_preset(eff) : st_q.crc;
        upd      = (rx_sof && eff.skip) ? base : crc_step_byte(base, eff.crc5, rx_data);
        exp5     = eff.inv ? ~base[CRC5_W-1:0] : base[CRC5_W-1:0];
        if (eff.crc5) match = (rx_data[CRC5_W-1:0] == exp5);
        else          match = (upd == (eff.inv ? RESIDUE_INV : RESIDUE_STD));
        if (rx_valid) begin
            st_d.crc = upd;
            if (rx_eof && eff.en) begin
                st_d.ok  = match;
                st_d.err = !match;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_crc_ok  = st_q.ok;
    assign rx_crc_err = st_q.err;

    // R10: a verdict only follows an end-of-frame byte
    p_strobe_after_eof_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_crc_ok || rx_crc_err) |-> $past(rx_valid && rx_eof));

    // R10: pass and fail never together
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_crc_ok, rx_crc_err}));

    // R12: checking disabled gives no verdict
    p_rx_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof && !eff.en) |=> !(rx_crc_ok || rx_crc_err));

endmodule

// File: rtl/crc_frame_engine.sv
module crc_frame_engine
    import crc_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cfg_preset_sel,
    input  logic [CRC_W-1:0]  cfg_preset_val,
    input  logic              cfg_crc5,
    input  logic              cfg_skip_first,
    input  logic              tx_crc_en,
    input  logic              tx_crc_inv,
    input  logic              rx_crc_en,
    input  logic              rx_crc_inv,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_sof,
    input  logic              tx_eof,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              tx_out_last,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              rx_crc_ok,
    output logic              rx_crc_err
);

    crc_cfg_t tx_cfg, rx_cfg;

    assign tx_cfg = '{sel: cfg_preset_sel, pval: cfg_preset_val, crc5: cfg_crc5,
                      skip: cfg_skip_first, inv: tx_crc_inv, en: tx_crc_en};
    assign rx_cfg = '{sel: cfg_preset_sel, pval: cfg_preset_val, crc5: cfg_crc5,
                      skip: cfg_skip_first, inv: rx_crc_inv, en: rx_crc_en};

    crc_tx_path u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_live     (tx_cfg),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_sof       (tx_sof),
        .tx_eof       (tx_eof),
        .tx_out_valid (tx_out_valid),
        .tx_out_data  (tx_out_data),
        .tx_out_last  (tx_out_last)
    );

    crc_rx_path u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_live   (rx_cfg),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_crc_ok  (rx_crc_ok),
        .rx_crc_err (rx_crc_err)
    );

endmodule

// File: tb/crc_frame_engine_tb.sv
module crc_frame_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_preset_sel = '0;
    logic [15:0] cfg_preset_val = 16'hA5C3;
    logic        cfg_crc5 = 0, cfg_skip_first = 0;
    logic        tx_crc_en = 1, tx_crc_inv = 0, rx_crc_en = 1, rx_crc_inv = 0;
    logic        tx_valid = 0, tx_sof = 0, tx_eof = 0;
    logic [7:0]  tx_data = '0;
    logic        rx_valid = 0, rx_sof = 0, rx_eof = 0;
    logic [7:0]  rx_data = '0;
    logic        tx_out_valid, tx_out_last, rx_crc_ok, rx_crc_err;
    logic [7:0]  tx_out_data;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    crc_frame_engine u_dut (.*);

    logic [7:0] cap_d [8];
    logic       cap_l [8];
    int cap_n = 0, ok_n = 0, err_n = 0;

    always @(negedge clk) begin
        if (tx_out_valid && cap_n < 8) begin
            cap_d[cap_n] = tx_out_data;
            cap_l[cap_n] = tx_out_last;
            cap_n++;
        end
        if (rx_crc_ok)  ok_n++;
        if (rx_crc_err) err_n++;
    end

    typedef struct packed {
        logic [2:0]  sel;
        logic        c5;
        logic        inv;
        logic        skip;
        logic [2:0]  len;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0000_0000},
        '{3'd1, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0000_3412},
        '{3'd3, 1'b0, 1'b1, 1'b0, 3'd3, 32'h0000_0000},
        '{3'd3, 1'b0, 1'b1, 1'b0, 3'd4, 32'h5634_120A},
        '{3'd0, 1'b0, 1'b0, 1'b0, 3'd3, 32'h0003_0201},
        '{3'd6, 1'b0, 1'b0, 1'b0, 3'd3, 32'h0003_0201},
        '{3'd7, 1'b0, 1'b0, 1'b0, 3'd2, 32'h0000_A55A},
        '{3'd2, 1'b0, 1'b0, 1'b1, 3'd3, 32'h0020_10FF},
        '{3'd4, 1'b1, 1'b0, 1'b0, 3'd2, 32'h0000_7E81},
        '{3'd5, 1'b1, 1'b1, 1'b0, 3'd3, 32'h0055_4433},
        '{3'd3, 1'b1, 1'b0, 1'b1, 3'd3, 32'h00F0_0FAA},
        '{3'd2, 1'b0, 1'b1, 1'b1, 3'd4, 32'h4433_2211}
    };

    function automatic logic [15:0] m_start(input logic [2:0] s, input logic [15:0] pv);
        case (s)
            3'd1: return 16'h6363;
            3'd2: return 16'hA671;
            3'd3: return 16'hFFFF;
            3'd4: return 16'h0012;
            3'd5: return 16'hE012;
            3'd7: return pv;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] m_crc(input logic [2:0] s, input logic c5, input logic skip,
                                          input logic [31:0] data, input int len);
        logic [15:0] r;
        logic [4:0]  q;
        logic [7:0]  b;
        r = m_start(s, cfg_preset_val);
        q = r[4:0];
        for (int i = 0; i < len; i++) begin
            b = data[8*i +: 8];
            if (!(skip && i == 0)) begin
                for (int k = 0; k < 8; k++) begin
                    if (c5) begin
                        if (q[4] ^ b[7-k]) q = {q[3:0], 1'b0} ^ 5'b01001;
                        else               q = {q[3:0], 1'b0};
                    end else begin
                        if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
                        else             r = r >> 1;
                    end
                end
            end
        end
        return c5 ? {11'd0, q} : r;
    endfunction

    task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_tx(input logic [31:0] d, input int len, input bit chg);
        cap_n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            tx_valid = 1; tx_data = d[8*i +: 8];
            tx_sof = (i == 0); tx_eof = (i == len-1);
            if (chg && i == 1) begin
                cfg_preset_sel = 3'd3; tx_crc_inv = 1; cfg_crc5 = 1; cfg_skip_first = 1;
            end
        end
        @(negedge clk);
        tx_valid = 0; tx_sof = 0; tx_eof = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_rx(input int n, input int flip_idx);
        ok_n = 0; err_n = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1;
            rx_data = (i == flip_idx) ? (cap_d[i] ^ 8'h01) : cap_d[i];
            rx_sof = (i == 0); rx_eof = (i == n-1);
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input logic [31:0] d, input int len,
                               input logic [2:0] s, input logic c5, input logic inv, input logic skip);
        logic [15:0] fcs;
        logic [63:0] act, exp;
        int n;
        fcs = m_crc(s, c5, skip, d, len);
        if (inv) fcs = c5 ? {11'd0, ~fcs[4:0]} : ~fcs;
        n = len + (c5 ? 1 : 2);
        chk(cap_n == n, {req, " length"}, 64'(cap_n), 64'(n));
        act = '0; exp = '0;
        for (int i = 0; i < n && i < 8; i++) begin
            act[8*i +: 8] = cap_d[i];
            if (i < len)       exp[8*i +: 8] = d[8*i +: 8];
            else if (i == len) exp[8*i +: 8] = fcs[7:0];
            else               exp[8*i +: 8] = fcs[15:8];
        end
        chk(act == exp, {req, " bytes"}, act, exp);
        act = '0; exp = '0;
        for (int i = 0; i < n && i < 8; i++) begin
            act[i] = cap_l[i];
            exp[i] = (i == n-1);
        end
        chk(act == exp, {req, " last marker"}, act, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({tx_out_valid, tx_out_data, tx_out_last, rx_crc_ok, rx_crc_err} == '0,
            "R1 reset outputs", 64'({tx_out_valid, tx_out_data, tx_out_last, rx_crc_ok, rx_crc_err}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Table: R2 R3 R4 R5 R6 R7 on transmit, R10 R11 loopback on receive
        for (int v = 0; v < NV; v++) begin
            cfg_preset_sel = VECS[v].sel; cfg_crc5 = VECS[v].c5;
            tx_crc_inv = VECS[v].inv; rx_crc_inv = VECS[v].inv;
            cfg_skip_first = VECS[v].skip;
            send_tx(VECS[v].data, int'(VECS[v].len), 0);
            check_frame(VECS[v].c5 ? "R4/R5/R6/R7 R2" : "R3/R5/R6/R7 R2",
                        VECS[v].data, int'(VECS[v].len), VECS[v].sel,
                        VECS[v].c5, VECS[v].inv, VECS[v].skip);
            send_rx(cap_n, -1);
            chk(ok_n == 1 && err_n == 0, VECS[v].c5 ? "R11 good frame" : "R10 good frame",
                64'({ok_n[7:0], err_n[7:0]}), 64'h0100);
            send_rx(cap_n, int'(VECS[v].len) - 1);
            chk(ok_n == 0 && err_n == 1, VECS[v].c5 ? "R11 corrupted frame" : "R10 corrupted frame",
                64'({ok_n[7:0], err_n[7:0]}), 64'h0001);
        end

        // R8: appending disabled
        cfg_preset_sel = 3'd1; cfg_crc5 = 0; cfg_skip_first = 0; tx_crc_inv = 0; tx_crc_en = 0;
        send_tx(32'h0033_2211, 3, 0);
        chk(cap_n == 3, "R8 no append length", 64'(cap_n), 3);
        chk(cap_l[2] == 1 && cap_l[0] == 0 && cap_d[2] == 8'h33, "R8 last on end byte",
            64'({cap_l[2], cap_d[2]}), 64'h133);
        tx_crc_en = 1;

        // R9: config changes after start-of-frame are ignored
        send_tx(32'h0056_3412, 3, 1);
        check_frame("R9 mid-frame change", 32'h0056_3412, 3, 3'd1, 0, 0, 0);
        cfg_preset_sel = 3'd1; cfg_crc5 = 0; cfg_skip_first = 0; tx_crc_inv = 0;

        // R12: receive checking disabled
        send_tx(32'h0000_3412, 2, 0);
        rx_crc_en = 0; rx_crc_inv = 0;
        send_rx(cap_n, -1);
        chk(ok_n == 0 && err_n == 0, "R12 no strobe when disabled",
            64'({ok_n[7:0], err_n[7:0]}), 0);
        rx_crc_en = 1;

        // R10: wrong inversion expectation fails
        rx_crc_inv = 1;
        send_rx(cap_n, -1);
        chk(ok_n == 0 && err_n == 1, "R10 residue mismatch on inversion",
            64'({ok_n[7:0], err_n[7:0]}), 64'h0001);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule